// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a clocked host and an asynchronous static RAM of 256K words by 8 bits. The host issues one-word read or write requests with a strobe, a write flag, an 18-bit address and write data. The controller turns each request into a memory cycle whose every phase lasts a whole number of clock cycles. These counts are derived when the design is built, from a clock-period parameter and the memory's minimum timing windows.

The memory is selected only while the active-low enable is low and the active-high enable is high. A write keeps the memory selected, pulls write enable low and drives the data bus. It ends by raising write enable while the memory is still selected, and the data drivers are released on that same edge. A read keeps write enable high and pulls output enable low. It captures the byte only after both the address access time and the output-enable access time have passed, then pulses a valid flag for one clock. When a write follows a read, the controller waits out the memory's output-disable time before it turns on its own drivers.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset and whenever ready is high, the memory is deselected (memCs1n=1, memCs2=0), memWen=1, memOen=1 and memDrvEn=0.
- R2: A request is taken only on a clock edge where ready is high. Ready is low from the edge after acceptance until the cycle finishes. A request held while busy has no effect on memory contents.
- R3: During a write, memWen stays low for at least 35 ns. The memory is selected at least 35 ns before memWen rises, and it is still selected when memWen rises.
- R4: Write data is driven for at least 25 ns before memWen rises. memDrvEn is high only while memWen is low, and it falls on the same edge at which memWen rises.
- R5: Every read or write cycle keeps the memory selected for at least 45 ns.
- R6: During a read, memWen is high and memOen is low. The captured byte is sampled no earlier than 45 ns after the address and chip select become valid, and no earlier than 22 ns after memOen falls. It equals the stored byte.
- R7: For a read accepted at edge E, ready is low for RD clock cycles, where RD = max(ceil(45/CLK_NS), ceil(22/CLK_NS)). rdValid is high for exactly the next cycle.
- R8: memDrvEn never rises sooner than 18 ns after memOen last rose, so the controller and the memory never drive the bus at the same time.
- R9: Bytes written at any address, including the lowest and highest, are read back unchanged.
- R10: Every phase count is ceil(window/CLK_NS), with a floor of one cycle. The write-enable pulse is max(ceil(35/CLK_NS), ceil(25/CLK_NS)) cycles. After it comes a hold phase of max(1, ceil(45/CLK_NS) minus the pulse length) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Request strobe, taken when hostRdy is high |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Word address |
| hostWdata | input | DATA_W | Byte to write |
| hostRdy | output | 1 | Controller idle and able to take a request |
| rdData | output | DATA_W | Last byte read |
| rdValid | output | 1 | One-cycle pulse when rdData holds a new byte |
| memCs1n | output | 1 | Active-low chip enable |
| memCs2 | output | 1 | Active-high chip enable |
| memWen | output | 1 | Active-low write enable |
| memOen | output | 1 | Active-low output enable |
| memAddr | output | ADDR_W | Memory address bus |
| memDq | inout | DATA_W | Bidirectional memory data bus |
| memDrvEn | output | 1 | High while the controller drives memDq |

## Verification
The hardest case to reach is a write issued on the very clock where a read's valid pulse appears. In that case output enable has only just risen, and the memory model is still driving the bus during its modelled output-disable window. The bench runs the controller with a small clock-period parameter, so the turnaround needs several cycles. It then chains read and write requests back to back on each valid cycle, and the bus model flags any overlap of the two drivers. A request held during a busy write is released before the controller goes idle, and a later read of its target address shows whether it leaked through.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WPULSE,
    ST_WEND,
    ST_RACC
  } ctlState_e;

  // strobes from control to datapath, describing the next pin state
  typedef struct packed {
    logic selOn;
    logic weOn;
    logic oeOn;
    logic drvOn;
    logic loadReq;
    logic capRead;
  } pinStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int atLeastOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS       = 20,
  parameter int T_CYCLE      = 45,
  parameter int T_WE_PULSE   = 35,
  parameter int T_DATA_SETUP = 25,
  parameter int T_SEL_TO_END = 35,
  parameter int T_ADDR_ACC   = 45,
  parameter int T_OE_ACC     = 22,
  parameter int T_OE_HIZ     = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       hostWr,
  output logic       hostRdy,
  output pinStrobe_t strobe
);

  localparam int WP_CYC  = atLeastOne(maxOf(ceilDiv(T_WE_PULSE, CLK_NS),
                             maxOf(ceilDiv(T_DATA_SETUP, CLK_NS), ceilDiv(T_SEL_TO_END, CLK_NS))));
  localparam int WC_CYC  = atLeastOne(ceilDiv(T_CYCLE, CLK_NS));
  localparam int WE_CYC  = atLeastOne(WC_CYC - WP_CYC);
  localparam int RD_CYC  = atLeastOne(maxOf(ceilDiv(T_ADDR_ACC, CLK_NS),
                             maxOf(ceilDiv(T_OE_ACC, CLK_NS), WC_CYC)));
  localparam int HZ_CYC  = atLeastOne(ceilDiv(T_OE_HIZ, CLK_NS));
  localparam int MAX_CYC = maxOf(maxOf(WP_CYC, WE_CYC), maxOf(RD_CYC, HZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctlState_e  state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic [CNT_W-1:0] hzCnt, nextHz;
  logic [CNT_W-1:0] weRun, rdRun;

  always_comb begin
    nextState = state;
    nextCnt   = (cnt > CNT_W'(1)) ? cnt - CNT_W'(1) : cnt;
    nextHz    = (hzCnt != '0) ? hzCnt - CNT_W'(1) : hzCnt;
    strobe    = '0;
    case (state)
      ST_IDLE: if (hostReq) begin
        strobe.loadReq = 1'b1;
        if (!hostWr) begin
          nextState = ST_RACC;
          nextCnt   = CNT_W'(RD_CYC);
        end else if (hzCnt > CNT_W'(1)) begin
          nextState = ST_TURN;
        end else begin
          nextState = ST_WPULSE;
          nextCnt   = CNT_W'(WP_CYC);
        end
      end
      ST_TURN: if (hzCnt <= CNT_W'(1)) begin
        nextState = ST_WPULSE;
        nextCnt   = CNT_W'(WP_CYC);
      end
      ST_WPULSE: if (cnt == CNT_W'(1)) begin
        nextState = ST_WEND;
        nextCnt   = CNT_W'(WE_CYC);
      end
      ST_WEND: if (cnt == CNT_W'(1)) nextState = ST_IDLE;
      ST_RACC: if (cnt == CNT_W'(1)) begin
        nextState      = ST_IDLE;
        strobe.capRead = 1'b1;
        nextHz         = CNT_W'(HZ_CYC);
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.selOn = (nextState != ST_IDLE);
    strobe.weOn  = (nextState == ST_WPULSE);
    strobe.drvOn = (nextState == ST_WPULSE);
    strobe.oeOn  = (nextState == ST_RACC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      hzCnt <= '0;
      weRun <= '0;
      rdRun <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      hzCnt <= nextHz;
      weRun <= (state == ST_WPULSE) ? weRun + CNT_W'(1) : '0;
      rdRun <= (state == ST_RACC) ? rdRun + CNT_W'(1) : '0;
    end
  end

  assign hostRdy = (state == ST_IDLE);

  // R3 / R10: write-enable pulse lasts exactly the derived cycle count
  a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WPULSE && nextState != ST_WPULSE) |-> (int'(weRun) == WP_CYC - 1));

  // R6 / R7: read capture only after the full access window
  a_r6_read_len: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capRead |-> (int'(rdRun) == RD_CYC - 1));

  // R8: drivers turn on only once the output-disable wait has run out
  a_r8_turn_wait: assert property (@(posedge clk) disable iff (!rstN)
    (nextState == ST_WPULSE && state != ST_WPULSE) |-> (hzCnt <= CNT_W'(1)));

  // R2: no new request is taken while a cycle is in flight
  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!hostRdy && state != ST_WEND && state != ST_RACC) |=> !hostRdy);

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pinStrobe_t        strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic              memCs1n,
  output logic              memCs2,
  output logic              memWen,
  output logic              memOen,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDrvEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCs1n  <= 1'b1;
      memCs2   <= 1'b0;
      memWen   <= 1'b1;
      memOen   <= 1'b1;
      memDrvEn <= 1'b0;
      memAddr  <= '0;
      memDout  <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      memCs1n  <= !strobe.selOn;
      memCs2   <= strobe.selOn;
      memWen   <= !strobe.weOn;
      memOen   <= !strobe.oeOn;
      memDrvEn <= strobe.drvOn;
      rdValid  <= strobe.capRead;
      if (strobe.loadReq) begin
        memAddr <= hostAddr;
        memDout <= hostWdata;
      end
      if (strobe.capRead) rdData <= memDin;
    end
  end

  // R4: controller drives the bus only inside the write-enable window
  a_r4_drv_in_window: assert property (@(posedge clk) disable iff (!rstN)
    memDrvEn |-> !memWen);

  // R3: write ends by write enable rising while still selected
  a_r3_end_selected: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWen) |-> (!memCs1n && memCs2 && !memDrvEn));

  // R6: output enable only with write enable high and the memory selected
  a_r6_oe_read_only: assert property (@(posedge clk) disable iff (!rstN)
    !memOen |-> (memWen && !memCs1n && memCs2));

  // R7: valid is a single-cycle pulse
  a_r7_valid_once: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostRdy,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memCs1n,
  output logic              memCs2,
  output logic              memWen,
  output logic              memOen,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memDq,
  output logic              memDrvEn
);

  pinStrobe_t        strobe;
  logic [DATA_W-1:0] memDout;

  sram_ctl_fsm #(.CLK_NS(CLK_NS)) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .hostReq (hostReq),
    .hostWr  (hostWr),
    .hostRdy (hostRdy),
    .strobe  (strobe)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .memDin    (memDq),
    .memCs1n   (memCs1n),
    .memCs2    (memCs2),
    .memWen    (memWen),
    .memOen    (memOen),
    .memAddr   (memAddr),
    .memDout   (memDout),
    .memDrvEn  (memDrvEn),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

  assign memDq = memDrvEn ? memDout : {DATA_W{1'bz}};

  // R1: an idle controller leaves the memory deselected and quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    hostRdy |-> (memCs1n && !memCs2 && memWen && memOen && !memDrvEn));

endmodule

// File: tb/sram_async_ctl_tb.sv
`timescale 1ns/100ps
module sram_async_ctl_tb;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int CLK_NS = 8;            // design-side period: stretches every phase
  localparam real SCALE = CLK_NS / 20.0; // real ns -> design ns
  localparam int RD_CYC = 6;             // max(ceil(45/8), ceil(22/8))

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReq = 1'b0, hostWr = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic hostRdy, rdValid, memCs1n, memCs2, memWen, memOen, memDrvEn;
  logic [DW-1:0] rdData;
  logic [AW-1:0] memAddr;
  wire  [DW-1:0] memDq;

  logic modelDrv = 1'b0;
  logic [DW-1:0] modelOut = '0;
  assign memDq = modelDrv ? modelOut : {DW{1'bz}};

  int checks = 0, failures = 0;
  logic [7:0] modelMem [int];
  logic [7:0] expMem [int];

  sram_async_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_NS)) u_dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdy(hostRdy),
    .rdData(rdData), .rdValid(rdValid), .memCs1n(memCs1n), .memCs2(memCs2),
    .memWen(memWen), .memOen(memOen), .memAddr(memAddr), .memDq(memDq),
    .memDrvEn(memDrvEn));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model and pin timing monitor, sampled half a real ns after each step
  bit monOn = 0;
  initial begin
    real now, tAddr, tSel, tOeFall, tOeRise, tLastAct, tWeFall, tDrvRise;
    logic [AW-1:0] pAddr;
    logic pSel, pOen, pWen, pDrv, sel, act;
    logic [7:0] wrLatch;
    tAddr = 0; tSel = 0; tOeFall = 0; tOeRise = -1000; tLastAct = -1000;
    tWeFall = 0; tDrvRise = 0; wrLatch = '0;
    pAddr = '0; pSel = 0; pOen = 1; pWen = 1; pDrv = 0;
    #0.5;
    forever begin
      if (monOn) begin
        now = $realtime * SCALE;
        sel = !memCs1n && memCs2;
        if (memAddr !== pAddr) tAddr = now;
        if (sel && !pSel) tSel = now;
        if (!memOen && pOen) tOeFall = now;
        if (memOen && !pOen) tOeRise = now;
        if (memDrvEn && !pDrv) begin
          tDrvRise = now;
          check(now - tOeRise >= 18.0, "R8 turnaround", int'(now - tOeRise), 18);
        end
        if (!memWen && pWen) tWeFall = now;
        if (!memWen && sel) wrLatch = memDq;
        if (memWen && !pWen) begin
          check(now - tWeFall >= 35.0, "R3 we pulse", int'(now - tWeFall), 35);
          check(sel && now - tSel >= 35.0, "R3 select to end", int'(now - tSel), 35);
          check(now - tDrvRise >= 25.0 && !memDrvEn, "R4 data setup/release",
                int'(now - tDrvRise), 25);
          modelMem[int'(memAddr)] = wrLatch;
        end
        if (!sel && pSel)
          check(now - tSel >= 45.0, "R5 cycle length", int'(now - tSel), 45);
        act = sel && !memOen && memWen;
        if (act) tLastAct = now;
        modelDrv = act || (now - tLastAct < 18.0);
        if (act && now - tAddr >= 45.0 && now - tSel >= 45.0 && now - tOeFall >= 22.0)
          modelOut = modelMem.exists(int'(memAddr)) ? modelMem[int'(memAddr)] : 8'hA5;
        else
          modelOut = 'x;
        if (memDrvEn && modelDrv)
          check(1'b0, "R8 bus contention", 32'(memDrvEn), 0);
        pAddr = memAddr; pSel = sel; pOen = memOen; pWen = memWen; pDrv = memDrvEn;
      end
      #1;
    end
  end

  function automatic logic [7:0] expOf(input int a);
    return expMem.exists(a) ? expMem[a] : 8'hA5;
  endfunction

  // caller sits at a negedge
  task automatic hostWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!hostRdy) @(negedge clk);
    hostReq = 1; hostWr = 1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostReq = 0;
    check(!hostRdy && !rdValid, "R2 busy after write accept", {hostRdy, rdValid}, 0);
    while (!hostRdy) @(negedge clk);
    expMem[int'(a)] = d;
  endtask

  task automatic hostRead(input logic [AW-1:0] a);
    bit busyOk;
    while (!hostRdy) @(negedge clk);
    hostReq = 1; hostWr = 0; hostAddr = a;
    @(negedge clk);
    hostReq = 0;
    busyOk = 1;
    for (int k = 1; k <= RD_CYC; k++) begin
      if (hostRdy || rdValid) busyOk = 0;
      if (k < RD_CYC) @(negedge clk);
    end
    check(busyOk, "R7 ready low for read window", 32'(busyOk), 1);
    @(negedge clk);
    check(rdValid && hostRdy, "R7 valid pulse timing", {rdValid, hostRdy}, 2'b11);
    check(rdData === expOf(int'(a)), "R6/R9 read data", rdData, expOf(int'(a)));
  endtask

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    monOn = 1;
    @(negedge clk);
    // R1 reset state
    check(memCs1n && !memCs2 && memWen && memOen && !memDrvEn && hostRdy && !rdValid,
          "R1 reset idle pins", {memCs1n, memCs2, memWen, memOen, memDrvEn, hostRdy, rdValid},
          7'b1011010);

    // R9 write sweep, low block plus both address extremes
    for (int a = 0; a < 40; a++) hostWrite(AW'(a), 8'((a * 29 + 7) & 255));
    hostWrite(18'h3FFFF, 8'h5A);
    hostWrite(18'h20000, 8'hC3);
    for (int a = 0; a < 40; a++) hostRead(AW'(a));
    hostRead(18'h3FFFF);
    hostRead(18'h20000);
    hostRead(18'h01234); // never written

    // R8 write issued on the read's valid cycle
    for (int i = 0; i < 8; i++) begin
      hostRead(AW'(i));
      hostWrite(AW'(100 + i), ~8'(i * 3));
    end
    for (int i = 0; i < 8; i++) hostRead(AW'(100 + i));

    // R2 request held while busy is ignored
    hostWrite(18'h00200, 8'h11);
    hostReq = 1; hostWr = 1; hostAddr = 18'h00300; hostWdata = 8'h22;
    @(negedge clk);
    hostAddr = 18'h00301; hostWdata = 8'h33;
    @(negedge clk);
    check(!hostRdy, "R2 still busy", 32'(hostRdy), 0);
    hostAddr = 18'h00302;
    @(negedge clk);
    hostReq = 0;
    while (!hostRdy) @(negedge clk);
    expMem[32'h300] = 8'h22;
    hostRead(18'h00300);
    hostRead(18'h00301); // R2: must still hold the unwritten default
    hostRead(18'h00302);

    @(negedge clk);
    check(memCs1n && !memCs2 && memWen && memOen && !memDrvEn, "R1 idle after traffic",
          {memCs1n, memCs2, memWen, memOen, memDrvEn}, 5'b10110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule